// File: doc/BRIEF.md
# RAM-Based Content Addressable Memory

This block is a small content addressable memory of 16 entries, each 8 bits wide. Its storage is one dual-port synchronous bit array in a transposed layout. The write side is 1 bit wide and has 4096 locations. The read side is 16 bits wide and has 256 locations. A lookup uses the search data directly as the read address. The word it reads back carries one bit per entry, and that bit is set when the entry holds the searched value. A lookup therefore costs one read, whatever the number of entries.

Each update is a two-phase sequence on the 1-bit side. First the bit that recorded the entry's old value is cleared. Then the bit for the new value is set. A shadow copy of every entry's value supplies the address for the clear. A per-entry written flag suppresses the clear for an entry that has never been written.

The surrounding logic issues a write with an entry index and a value. It then waits for the busy flag to drop. Lookups may be issued on any cycle, and each returns a match vector with a one-cycle valid strobe.

Top module: `ram_cam`

## Requirements
- R1: After reset, busy_o and match_valid_o are 0, match_o is all zeros, and a lookup of any of the 256 values returns an all-zero vector.
- R2: A write request seen while busy_o is 0 is accepted. busy_o is 1 in exactly the two cycles after the request cycle and 0 in the cycle after that.
- R3: A write request seen while busy_o is 1 is dropped. The entry keeps the value from the accepted write, and no other entry changes.
- R4: A lookup requested in cycle t gives match_valid_o = 1 in cycle t+1 only. match_o then carries bit e = 1 exactly when entry e has been written and holds the lookup value, and it holds until the next lookup or clear.
- R5: When several entries hold the same value, a lookup of that value sets the bit of every one of them.
- R6: Rewriting an entry with a new value clears its bit for the old value and sets it for the new value. Other entries holding the old value still match it.
- R7: Rewriting an entry with the value it already holds leaves its bit set for that value.
- R8: An entry that has never been written matches no value, including 0x00. The first write to an entry disturbs no other entry.
- R9: match_clr_i = 1 in cycle t forces match_o to all zeros and match_valid_o to 0 in cycle t+1, even if a lookup is requested in the same cycle.
- R10: A write that completes with busy_o falling before cycle t is visible to a lookup requested in cycle t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both sides of the bit array |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_i | input | 1 | Write request, one cycle |
| wr_entry_i | input | 4 | Index of the entry to write |
| wr_data_i | input | 8 | New value for the entry |
| busy_o | output | 1 | Update in progress; further write requests are dropped |
| match_req_i | input | 1 | Lookup request |
| match_data_i | input | 8 | Value to search for |
| match_clr_i | input | 1 | Synchronous clear of the match result |
| match_o | output | 16 | One bit per entry that holds the searched value |
| match_valid_o | output | 1 | Strobe that marks a fresh lookup result |

## Verification
A wrong shadow value or written flag makes the clear phase hit the wrong bit. That stale bit then shows up as an extra match bit on the old value in the first lookup after the rewrite, which is one cycle after the request. A broken sequencer shows up at once as a busy window that is not two cycles long, or as a dropped request that overwrites the entry. To catch a fault left in any of the 256 rows, the bench sweeps every value against an independent model after each phase of writes.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    UPD_IDLE  = 2'd0,
    UPD_ERASE = 2'd1,
    UPD_WRITE = 2'd2
  } upd_state_e;
endpackage

// File: rtl/cam_bit_ram.sv
module cam_bit_ram #(
  parameter int unsigned N_ENTRY = 16,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned IDX_W  = $clog2(N_ENTRY),
  localparam int unsigned ADDR_W = DATA_W + IDX_W,
  localparam int unsigned DEPTH  = 1 << DATA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic               wr_bit_i,
  input  logic               rd_en_i,
  input  logic               rd_clr_i,
  input  logic [DATA_W-1:0]  rd_addr_i,
  output logic [N_ENTRY-1:0] rd_data_o
);
  logic [N_ENTRY-1:0] mem_q [DEPTH];
  logic [N_ENTRY-1:0] rd_q;
  logic [DATA_W-1:0]  wr_row;
  logic [IDX_W-1:0]   wr_col;

  // narrow side address = {value, entry}
  assign wr_row = wr_addr_i[ADDR_W-1:IDX_W];
  assign wr_col = wr_addr_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < DEPTH; r++) mem_q[r] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_row][wr_col] <= wr_bit_i;
    end
  end

  // read-before-write on the wide side, sync output clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rd_q <= '0;
    else if (rd_clr_i) rd_q <= '0;
    else if (rd_en_i)  rd_q <= mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_q;

  AST_RD_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clr_i |=> rd_data_o == '0); // R9
  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && !rd_clr_i) |=> $stable(rd_data_o)); // R4
endmodule

// File: rtl/cam_upd_fsm.sv
module cam_upd_fsm
  import cam_pkg::*;
#(
  parameter int unsigned N_ENTRY = 16,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned IDX_W  = $clog2(N_ENTRY),
  localparam int unsigned ADDR_W = DATA_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [IDX_W-1:0]  wr_entry_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              busy_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_bit_o
);
  upd_state_e                      state_q;
  logic [IDX_W-1:0]                ent_q;
  logic [DATA_W-1:0]               dat_q;
  logic [N_ENTRY-1:0][DATA_W-1:0]  val_q;
  logic [N_ENTRY-1:0]              used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= UPD_IDLE;
      ent_q   <= '0;
      dat_q   <= '0;
    end else begin
      unique case (state_q)
        UPD_IDLE: if (wr_req_i) begin
          state_q <= UPD_ERASE;
          ent_q   <= wr_entry_i;
          dat_q   <= wr_data_i;
        end
        UPD_ERASE: state_q <= UPD_WRITE;
        UPD_WRITE: state_q <= UPD_IDLE;
        default:   state_q <= UPD_IDLE;
      endcase
    end
  end

  // shadow copy of each entry's value, used to find the bit to erase
  for (genvar i = 0; i < N_ENTRY; i++) begin : g_shadow
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[i]  <= '0;
        used_q[i] <= 1'b0;
      end else if (state_q == UPD_WRITE && ent_q == IDX_W'(i)) begin
        val_q[i]  <= dat_q;
        used_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    ram_we_o   = 1'b0;
    ram_bit_o  = 1'b0;
    ram_addr_o = {dat_q, ent_q};
    unique case (state_q)
      UPD_ERASE: begin
        ram_we_o   = used_q[ent_q];
        ram_addr_o = {val_q[ent_q], ent_q};
      end
      UPD_WRITE: begin
        ram_we_o  = 1'b1;
        ram_bit_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign busy_o = (state_q != UPD_IDLE);

  AST_ERASE_THEN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == UPD_ERASE |=> state_q == UPD_WRITE); // R2
  AST_WRITE_THEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == UPD_WRITE |=> state_q == UPD_IDLE); // R2
  AST_BUSY_DROPS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> state_q != UPD_ERASE); // R3
  AST_SHADOW_ONLY_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(val_q) |-> $past(state_q == UPD_WRITE)); // R6
  AST_FIRST_WRITE_NO_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == UPD_ERASE && !used_q[ent_q]) |-> !ram_we_o); // R8
endmodule

// File: rtl/ram_cam.sv
module ram_cam #(
  parameter int unsigned N_ENTRY = 16,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned IDX_W  = $clog2(N_ENTRY),
  localparam int unsigned ADDR_W = DATA_W + IDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_req_i,
  input  logic [IDX_W-1:0]   wr_entry_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  output logic               busy_o,
  input  logic               match_req_i,
  input  logic [DATA_W-1:0]  match_data_i,
  input  logic               match_clr_i,
  output logic [N_ENTRY-1:0] match_o,
  output logic               match_valid_o
);
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_bit;
  logic              valid_q;

  cam_upd_fsm #(.N_ENTRY(N_ENTRY), .DATA_W(DATA_W)) u_upd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_req_i   (wr_req_i),
    .wr_entry_i (wr_entry_i),
    .wr_data_i  (wr_data_i),
    .busy_o     (busy_o),
    .ram_we_o   (ram_we),
    .ram_addr_o (ram_addr),
    .ram_bit_o  (ram_bit)
  );

  cam_bit_ram #(.N_ENTRY(N_ENTRY), .DATA_W(DATA_W)) u_ram (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (ram_we),
    .wr_addr_i (ram_addr),
    .wr_bit_i  (ram_bit),
    .rd_en_i   (match_req_i),
    .rd_clr_i  (match_clr_i),
    .rd_addr_i (match_data_i),
    .rd_data_o (match_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= match_req_i && !match_clr_i;
  end

  assign match_valid_o = valid_q;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_req_i && !match_clr_i) |=> match_valid_o); // R4
  AST_CLR_KILLS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_clr_i |=> !match_valid_o && match_o == '0); // R9
  AST_NO_VALID_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match_req_i |=> !match_valid_o); // R4
endmodule

// File: tb/tb_ram_cam.sv
module tb_ram_cam;
  localparam int N = 16;
  localparam int W = 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_req_i = 1'b0;
  logic [3:0]    wr_entry_i = '0;
  logic [W-1:0]  wr_data_i = '0;
  logic          busy_o;
  logic          match_req_i = 1'b0;
  logic [W-1:0]  match_data_i = '0;
  logic          match_clr_i = 1'b0;
  logic [N-1:0]  match_o;
  logic          match_valid_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  logic [W-1:0] mval [N];
  bit           mused [N];

  ram_cam dut (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run hung");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] model(logic [W-1:0] d);
    logic [N-1:0] v = '0;
    for (int e = 0; e < N; e++) if (mused[e] && mval[e] == d) v[e] = 1'b1;
    return v;
  endfunction

  // R2 timing of busy checked on every write
  task automatic do_write(int e, logic [W-1:0] d);
    @(negedge clk_i);
    wr_req_i = 1'b1; wr_entry_i = 4'(e); wr_data_i = d;
    @(negedge clk_i);
    wr_req_i = 1'b0;
    chk("R2 busy c1", 32'(busy_o), 32'd1);
    @(negedge clk_i);
    chk("R2 busy c2", 32'(busy_o), 32'd1);
    @(negedge clk_i);
    chk("R2 busy drop", 32'(busy_o), 32'd0);
    mval[e] = d; mused[e] = 1;
  endtask

  task automatic do_match(string req, logic [W-1:0] d, logic [N-1:0] exp);
    @(negedge clk_i);
    match_req_i = 1'b1; match_data_i = d;
    @(negedge clk_i);
    match_req_i = 1'b0;
    chk({req, " R4 valid"}, 32'(match_valid_o), 32'd1);
    chk(req, 32'(match_o), 32'(exp));
  endtask

  task automatic sweep(string req);
    for (int d = 0; d < 256; d++) begin
      @(negedge clk_i);
      match_req_i = 1'b1; match_data_i = W'(d);
      @(negedge clk_i);
      match_req_i = 1'b0;
      chk(req, 32'(match_o), 32'(model(W'(d))));
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", 32'(busy_o), 32'd0);
    chk("R1 valid", 32'(match_valid_o), 32'd0);
    chk("R1 match", 32'(match_o), 32'd0);
    sweep("R1 empty sweep");
  endtask

  task automatic t_hold();
    do_match("R4 hold setup", 8'h3C, model(8'h3C));
    @(negedge clk_i);
    chk("R4 valid one cycle", 32'(match_valid_o), 32'd0);
    chk("R4 vector holds", 32'(match_o), 32'(model(8'h3C)));
  endtask

  task automatic t_first_write();
    do_write(3, 8'h00);
    do_match("R8 zero value", 8'h00, 16'h0008);
  endtask

  task automatic t_duplicates();
    do_write(0, 8'h5A);
    do_write(7, 8'h5A);
    do_write(15, 8'h5A);
    do_match("R5 shared value", 8'h5A, 16'h8081);
  endtask

  task automatic t_rewrite();
    do_write(7, 8'hC3);
    do_match("R6 old value", 8'h5A, 16'h8001);
    do_match("R6 new value", 8'hC3, 16'h0080);
    do_write(0, 8'h5A);
    do_match("R7 same value", 8'h5A, 16'h8001);
  endtask

  task automatic t_busy_drop();
    @(negedge clk_i);
    wr_req_i = 1'b1; wr_entry_i = 4'd5; wr_data_i = 8'hA1;
    @(negedge clk_i);
    wr_entry_i = 4'd5; wr_data_i = 8'hB2;
    @(negedge clk_i);
    wr_entry_i = 4'd6;
    @(negedge clk_i);
    wr_req_i = 1'b0;
    chk("R2 busy drop after accept", 32'(busy_o), 32'd0);
    mval[5] = 8'hA1; mused[5] = 1;
    do_match("R3 dropped value", 8'hB2, 16'h0000);
    do_match("R3 kept value", 8'hA1, 16'h0020);
  endtask

  task automatic t_visible();
    @(negedge clk_i);
    wr_req_i = 1'b1; wr_entry_i = 4'd9; wr_data_i = 8'h77;
    @(negedge clk_i);
    wr_req_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    mval[9] = 8'h77; mused[9] = 1;
    // lookup in the first cycle with busy low
    match_req_i = 1'b1; match_data_i = 8'h77;
    @(negedge clk_i);
    match_req_i = 1'b0;
    chk("R10 immediate visibility", 32'(match_o), 32'h0200);
  endtask

  task automatic t_clear();
    do_match("R9 setup", 8'h5A, 16'h8001);
    @(negedge clk_i);
    match_clr_i = 1'b1; match_req_i = 1'b1; match_data_i = 8'h5A;
    @(negedge clk_i);
    match_clr_i = 1'b0; match_req_i = 1'b0;
    chk("R9 vector cleared", 32'(match_o), 32'd0);
    chk("R9 valid low", 32'(match_valid_o), 32'd0);
  endtask

  task automatic t_full();
    for (int e = 0; e < N; e++) do_write(e, W'(e * 37 + 11));
    do_write(2, 8'h0B);
    do_write(4, 8'hEE);
    sweep("R6 full sweep");
  endtask

  initial begin
    for (int e = 0; e < N; e++) begin mval[e] = '0; mused[e] = 0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_hold();
    t_first_write();
    t_duplicates();
    t_rewrite();
    t_busy_drop();
    t_visible();
    t_clear();
    sweep("R4 partial sweep");
    t_full();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule